// File: doc/BRIEF.md
# Receive Frame Length Classifier

This block sits on a byte-wide receive stream. Each byte carries a valid strobe, and start-of-frame and end-of-frame markers that count only on valid bytes. The block counts the bytes of every frame and compares the total with a programmable length limit. When the closing byte arrives it samples three error flags from upstream logic: checksum, symbol-code and alignment. It then marks the frame as over-length. An over-length frame is one of two kinds: a clean oversized frame, or a jabber frame, which also has at least one error flag set.

The length limit sits in the low 16 bits of a 32-bit register. The register has a one-signal write port and a read-back bus that is always present. The limit is latched when a frame starts, so a write made during a frame does not change how that frame is judged. For each frame kind, a counter of parameter width holds the number of frames seen. Both counters stop at all ones and clear on a strobe.

Top module: `rx_len_classifier`

## Requirements
- R1: After reset, `reg_rdata` reads 0x000005EE (a limit of 1518), all three class pulses are low and both counters are zero.
- R2: A write of `reg_wdata` stores bits 15:0 as the limit. Bits 31:16 of the write are discarded and read back as zero. Without a write, the register holds its value.
- R3: A frame is long only when its byte count, sof byte and eof byte both included, is strictly greater than the limit. A count equal to the limit is not long.
- R4: A long frame whose three error flags are all clear at its eof byte is reported as oversized only.
- R5: A long frame with any of `err_crc`, `err_code` or `err_align` set at its eof byte is reported as jabber only. A frame that is not long reports nothing, whatever its error flags.
- R6: `frm_long`, `frm_oversize` and `frm_jabber` are high for exactly one cycle: the cycle after the eof byte is accepted. At no other time are they high.
- R7: The byte count stops at 0xFFFF. A frame of more than 65535 bytes counts as 65535, so with a limit of 0xFFFE it is long.
- R8: `cnt_oversize` and `cnt_jabber` each add one per reported frame of their kind, stop at all ones (CNT_W bits, 32 by default), and go to zero on `stat_clr`.
- R9: The limit in force for a frame is the register value at its sof byte. A write made during the frame applies from the next sof.
- R10: A sof byte inside an unfinished frame drops that frame without any report and starts a new count. An eof byte outside any frame produces no report.
- R11: While `rx_valid` is low, the sof, eof and error inputs are ignored and no byte is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A byte is present this cycle |
| rx_sof | input | 1 | The byte opens a frame |
| rx_eof | input | 1 | The byte closes a frame |
| err_crc | input | 1 | Checksum error, sampled with the eof byte |
| err_code | input | 1 | Symbol code error, sampled with the eof byte |
| err_align | input | 1 | Alignment error, sampled with the eof byte |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read-back |
| stat_clr | input | 1 | Clears both counters |
| frm_long | output | 1 | Pulse: the last frame was over the limit |
| frm_oversize | output | 1 | Pulse: the last frame was long and clean |
| frm_jabber | output | 1 | Pulse: the last frame was long with an error |
| cnt_oversize | output | CNT_W | Count of oversized frames |
| cnt_jabber | output | CNT_W | Count of jabber frames |

## Verification
The bench probes the limit from both sides: a frame exactly at the limit must stay quiet, and a frame one byte longer must fire. A design that compares with >= fails the first case, and one that counts off by one fails one case or the other. A limit write during a frame, a restart before eof, a stray eof, and idle cycles carrying garbage markers catch a design that reads the live register or that classifies dropped and phantom frames. A 70000-byte frame against a limit of 0xFFFE exposes a counter that wraps. A narrow counter instance driven past all ones exposes statistics that roll back to zero.

// File: rtl/rx_len_classifier.sv
module rx_len_classifier #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int REG_W = 32,
  parameter logic [LEN_W-1:0] MAX_RST = 16'd1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic             err_crc,
  input  logic             err_code,
  input  logic             err_align,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             stat_clr,
  output logic             frm_long,
  output logic             frm_oversize,
  output logic             frm_jabber,
  output logic [CNT_W-1:0] cnt_oversize,
  output logic [CNT_W-1:0] cnt_jabber
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [LEN_W-1:0] max_q, lim_q, cnt_q;
  logic             in_q;

  wire start = rx_valid & rx_sof;
  wire take  = rx_valid & ~rx_sof & in_q;
  wire done  = rx_valid & rx_eof & (rx_sof | in_q);
  wire bad   = err_crc | err_code | err_align;

  wire [LEN_W-1:0] cnt_nx = start ? ONE : ((&cnt_q) ? cnt_q : cnt_q + ONE);
  wire [LEN_W-1:0] lim_nx = start ? max_q : lim_q;
  wire             is_long = done & (cnt_nx > lim_nx);

  assign reg_rdata = {{(REG_W-LEN_W){1'b0}}, max_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= MAX_RST;
      lim_q <= MAX_RST;
      cnt_q <= '0;
      in_q  <= 1'b0;
    end else begin
      if (reg_we) max_q <= reg_wdata[LEN_W-1:0];
      if (start) lim_q <= max_q;
      if (start | take) cnt_q <= cnt_nx;
      if (start | done) in_q <= start & ~done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_long     <= 1'b0;
      frm_oversize <= 1'b0;
      frm_jabber   <= 1'b0;
    end else begin
      frm_long     <= is_long;
      frm_oversize <= is_long & ~bad;
      frm_jabber   <= is_long & bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_oversize <= '0;
      cnt_jabber   <= '0;
    end else if (stat_clr) begin
      cnt_oversize <= '0;
      cnt_jabber   <= '0;
    end else begin
      if (frm_oversize && !(&cnt_oversize)) cnt_oversize <= cnt_oversize + 1'b1;
      if (frm_jabber && !(&cnt_jabber))     cnt_jabber   <= cnt_jabber + 1'b1;
    end
  end

  p_one_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_oversize && frm_jabber));
  p_long_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_long |-> (frm_oversize || frm_jabber));
  p_class_needs_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_oversize || frm_jabber) |-> frm_long);
  p_pulse_after_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_long |-> $past(rx_valid && rx_eof));
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && !frm_oversize) |=> $stable(cnt_oversize));
  p_limit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(reg_rdata));
endmodule

// File: tb/rx_len_classifier_bench.sv
`timescale 1ns/1ps
module rx_len_classifier_bench;
  localparam int CW = 4;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, err_crc = 0, err_code = 0, err_align = 0;
  logic reg_we = 0, stat_clr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic frm_long, frm_oversize, frm_jabber;
  logic [CW-1:0] cnt_oversize, cnt_jabber;

  always #5 clk = ~clk;

  rx_len_classifier #(.CNT_W(CW)) u_rx_len_classifier (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .err_crc(err_crc), .err_code(err_code), .err_align(err_align),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_clr(stat_clr),
    .frm_long(frm_long), .frm_oversize(frm_oversize), .frm_jabber(frm_jabber),
    .cnt_oversize(cnt_oversize), .cnt_jabber(cnt_jabber));

  int tests = 0, fails = 0;
  logic [2:0] expq[$];
  logic [15:0] m_max = 16'd1518, m_lim = 0, m_cnt = 0;
  logic m_in = 0;
  int m_over = 0, m_jab = 0;
  bit done_flag = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic byte_in(bit sof, bit eof, bit crc, bit code, bit align);
    logic [2:0] e;
    @(posedge clk); #1;
    reg_we = 0; stat_clr = 0;
    rx_valid = 1; rx_sof = sof; rx_eof = eof;
    err_crc = crc; err_code = code; err_align = align;
    if (sof) begin m_cnt = 1; m_lim = m_max; m_in = 1; end
    else if (m_in && m_cnt != 16'hFFFF) m_cnt = m_cnt + 1;
    if (eof) begin
      e = 3'b000;
      if (m_in && m_cnt > m_lim) begin
        if (crc | code | align) begin e = 3'b101; if (m_jab < 15) m_jab++; end
        else begin e = 3'b110; if (m_over < 15) m_over++; end
      end
      expq.push_back(e);
      m_in = 0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      reg_we = 0; stat_clr = 0;
      rx_valid = 0; rx_sof = 1; rx_eof = 1; err_crc = 1; err_code = 1; err_align = 1;
    end
  endtask

  task automatic frame(int len, bit crc, bit code, bit align);
    for (int i = 0; i < len; i++)
      byte_in(i == 0, i == len - 1, (i == len - 1) & crc, (i == len - 1) & code, (i == len - 1) & align);
  endtask

  task automatic wr(logic [31:0] d);
    @(posedge clk); #1;
    rx_valid = 0; reg_we = 1; reg_wdata = d; m_max = d[15:0];
  endtask

  task automatic chk_cnt(string req);
    idle(3);
    chk({req, " over"}, cnt_oversize, m_over);
    chk({req, " jab"}, cnt_jabber, m_jab);
  endtask

  initial begin : monitor
    bit hit;
    logic [2:0] e;
    forever begin
      @(posedge clk);
      hit = rst_n && rx_valid && rx_eof;
      @(negedge clk);
      if (hit) begin
        e = (expq.size() > 0) ? expq.pop_front() : 3'b000;
        chk("R3/R4/R5/R6 class", {frm_long, frm_oversize, frm_jabber}, e);
      end else if (frm_long | frm_oversize | frm_jabber) begin
        fails++;
        $display("FAIL R6 spurious pulse actual=%b expected=000", {frm_long, frm_oversize, frm_jabber});
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reg", reg_rdata, 32'h5EE);
    chk("R1 pulses", {frm_long, frm_oversize, frm_jabber}, 0);
    chk("R1 cnt", {cnt_oversize, cnt_jabber}, 0);

    frame(1518, 0, 0, 0);
    frame(1519, 0, 0, 0);
    idle(2);

    wr(32'hABCD_0040);
    idle(1);
    @(negedge clk);
    chk("R2 upper dropped", reg_rdata, 32'h0000_0040);

    frame(64, 0, 0, 0);   // R3 equal, not long
    frame(65, 0, 0, 0);   // R3/R4 oversized
    frame(65, 1, 0, 0);   // R5 crc jabber
    frame(65, 0, 1, 0);   // R5 code jabber
    frame(65, 0, 0, 1);   // R5 align jabber
    frame(10, 1, 1, 1);   // R5 short with errors: nothing
    chk_cnt("R8");

    wr(32'h0);
    frame(1, 0, 0, 0);    // R3 single byte over limit 0
    frame(1, 1, 0, 0);
    idle(2);

    wr(32'd100);          // R9
    for (int i = 0; i < 5; i++) byte_in(i == 0, 0, 0, 0, 0);
    wr(32'd10);
    for (int i = 0; i < 45; i++) byte_in(0, i == 44, 0, 0, 0);
    frame(50, 0, 0, 0);
    idle(2);

    wr(32'd100);          // R10
    frame(200, 0, 0, 0);
    for (int i = 0; i < 200; i++) byte_in(i == 0, 0, 0, 0, 0);
    frame(5, 0, 0, 0);
    byte_in(0, 1, 0, 0, 0);
    idle(2);

    wr(32'd20);           // R11
    for (int i = 0; i < 20; i++) begin
      byte_in(i == 0, i == 19, 0, 0, 0);
      if (i < 19) idle(2);
    end
    frame(21, 0, 0, 0);
    idle(2);

    wr(32'h0000_FFFE);    // R7
    frame(70000, 0, 0, 0);
    chk_cnt("R7 R8");

    wr(32'd2);            // R8 saturation
    for (int i = 0; i < 14; i++) frame(3, 0, 0, 0);
    chk_cnt("R8 sat");
    chk("R8 at max", cnt_oversize, 15);
    @(posedge clk); #1 stat_clr = 1; m_over = 0; m_jab = 0;
    chk_cnt("R8 clear");

    idle(4);
    chk("scoreboard empty", expq.size(), 0);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule